// File: doc/BRIEF.md
# Synthesizer Tuning-Word Receiver (I2C Write Slave)

This block is a write-only I2C slave that a host uses to program a frequency synthesizer. It runs on a fast system clock and synchronises SCL and SDA to that clock. It finds START and STOP conditions and compares the first byte of every transfer with its own write address. Two bits of that address come from a pin-strapped select input, so up to four of these receivers can share one bus. When the address matches, the block acknowledges that byte and every data byte after it by pulling SDA low for the ninth clock.

The data bytes carry no sub-address. The top bit of a byte that opens a pair selects which pair it opens. A clear top bit opens the divider pair, and the next byte ends that pair. A set top bit opens the control pair, and the next byte ends that pair too. The pairs may come in either order, and a STOP may end a transfer after only the first byte of a pair. The 15-bit scaling factor is loaded into the output as a single update, and only when the second divider byte arrives. The four charge-pump and loop-control flags are applied as soon as the first control byte arrives. The five switch enables are applied when the second control byte arrives.

State machine (`i2c_slave_fsm`): IDLE (bus free or finished), ADDR (shifting the address byte), ACK_ADDR (pulling SDA for the address acknowledge), DATA (shifting a data byte), ACK_DATA (pulling SDA for a data acknowledge), IGNORE (address mismatch; waits without driving SDA). Transitions: START from any state goes to ADDR, and STOP from any state goes to IDLE. ADDR goes to ACK_ADDR on the SCL fall after eight bits if the address matches, and to IGNORE if it does not. ACK_ADDR goes to DATA on the next SCL fall. DATA goes to ACK_DATA on the SCL fall after eight bits. ACK_DATA goes back to DATA on the next SCL fall. Pair tracking (`synth_word_regs`) has three phases: FIRST (next byte is classified by its top bit), DIV2 (next byte is the divider low byte) and CTL2 (next byte is the switch byte). An address match returns the tracker to FIRST.

Top module: `synth_i2c_prog`

## Requirements
- R1: The slave acknowledges an address byte equal to {1,1,0,0,0,addr_sel[1],addr_sel[0],0}. This gives addresses 192, 194, 196 and 198 for addr_sel values 0 to 3.
- R2: After a matching address byte, and after every data byte that follows it, sda_pull is 1 while SCL is high in the ninth clock. It is 0 again once SCL has fallen at the end of that clock.
- R3: An address byte that does not match, including a matching address with its lowest bit (the read bit) set, is never acknowledged. Data bytes that follow it are neither acknowledged nor applied to any output.
- R4: A byte that opens a pair with bit 7 = 0 supplies scale_factor[14:8] from its bits 6..0. The byte after it supplies scale_factor[7:0]. scale_factor changes only when that second byte arrives, so a transfer that stops after the first divider byte leaves scale_factor unchanged.
- R5: A byte that opens a pair with bit 7 = 1 is applied at once. Bit 6 drives cp_high, bit 5 drives div_test, bit 4 drives cp_off and bit 0 drives drv_off. Bits 3..1 have no effect.
- R6: The byte after a control-opening byte drives sw_on. Bits 7, 6, 5 and 4 drive sw_on[4], sw_on[3], sw_on[2] and sw_on[1], and bit 1 drives sw_on[0]. A 1 turns the switch on. Bits 3, 2 and 0 have no effect.
- R7: The divider pair and the control pair are accepted in either order within one transfer. After a pair is complete, the next byte is classified again by its bit 7. A new matched address restarts classification, so a pair left incomplete by a STOP does not carry over.
- R8: After reset, scale_factor, all control flags and sw_on are 0, and sda_pull is 0.
- R9: A repeated START without a STOP begins a new address phase, and the slave acknowledges and decodes the new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| addr_sel | input | 2 | Address select bits (bit 1 to address bit 2, bit 0 to address bit 1) |
| sda_pull | output | 1 | 1 = drive SDA low (acknowledge) |
| scale_factor | output | 15 | Programmable divider ratio |
| cp_high | output | 1 | Charge-pump high current select |
| div_test | output | 1 | Divider test mode |
| cp_off | output | 1 | Charge-pump disable |
| drv_off | output | 1 | Tuning driver disable |
| sw_on | output | 5 | Switch enables, bit 4 down to bit 0 |

## Verification
The bench sweeps every address-select setting against every candidate address and against the read-bit variant. A wrong address compare would acknowledge a neighbour's address or the read address, or it would let foreign data change the outputs. The bench walks a one through every bit of the scaling factor and also sends the extreme values and alternating patterns. It sends transfers that stop after only the first divider byte. A design that loads the high byte early, swaps the byte halves or drops a bit would show a wrong or partial ratio. The bench sweeps the control and switch bytes with their unused bits toggled, so a misplaced bit or an unused bit that has an effect shows at once. Ordered, truncated and repeated-START transfers catch a pair tracker that fails to reset at a new address or that misreads a control byte as the second divider byte.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_DATA,
        ST_ACK_DATA,
        ST_IGNORE
    } bus_state_t;

    typedef enum logic [1:0] {
        PH_FIRST,
        PH_DIV2,
        PH_CTL2
    } pair_phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_sh[STAGES-1];
            sda_d <= sda_sh[STAGES-1];
        end
    end

    always_comb begin
        scl_lvl   = scl_sh[STAGES-1];
        sda_lvl   = sda_sh[STAGES-1];
        scl_rise  = scl_lvl & ~scl_d;
        scl_fall  = ~scl_lvl & scl_d;
        start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
        stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import synth_i2c_pkg::*;
#(
    parameter int          BYTE_BITS = 8,
    parameter logic [4:0]  ADDR_HI   = 5'b11000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sda_lvl,
    input  logic                 scl_lvl,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_evt,
    input  logic                 stop_evt,
    input  logic [1:0]           addr_sel,
    output logic                 sda_pull,
    output logic                 byte_vld,
    output logic                 txn_start,
    output logic [BYTE_BITS-1:0] rx_byte
);
    localparam int CW = $clog2(BYTE_BITS + 1);
    localparam logic [CW-1:0] FULL = CW'(BYTE_BITS);

    bus_state_t           state, nxt;
    logic [CW-1:0]        bit_cnt;
    logic [BYTE_BITS-1:0] shreg;
    logic                 addr_hit;
    logic                 byte_done;

    assign addr_hit  = (shreg == {ADDR_HI, addr_sel, 1'b0});
    assign byte_done = scl_fall && (bit_cnt == FULL);
    assign rx_byte   = shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_evt) begin
            nxt = ST_ADDR;
        end else if (stop_evt) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done) nxt = addr_hit ? ST_ACK_ADDR : ST_IGNORE;
                ST_ACK_ADDR: if (scl_fall)  nxt = ST_DATA;
                ST_DATA:     if (byte_done) nxt = ST_ACK_DATA;
                ST_ACK_DATA: if (scl_fall)  nxt = ST_DATA;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (start_evt) begin
            bit_cnt <= '0;
        end else if ((state == ST_ADDR || state == ST_DATA) && scl_rise
                     && bit_cnt != FULL) begin
            shreg   <= {shreg[BYTE_BITS-2:0], sda_lvl};
            bit_cnt <= bit_cnt + 1'b1;
        end else if ((state == ST_ACK_ADDR || state == ST_ACK_DATA) && scl_fall) begin
            bit_cnt <= '0;
        end
    end

    // registered strobes toward the word registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_vld  <= 1'b0;
            txn_start <= 1'b0;
        end else begin
            byte_vld  <= (state == ST_DATA) && byte_done && !start_evt && !stop_evt;
            txn_start <= (state == ST_ADDR) && byte_done && addr_hit
                         && !start_evt && !stop_evt;
        end
    end

    // outputs
    always_comb begin
        sda_pull = (state == ST_ACK_ADDR) || (state == ST_ACK_DATA);
    end

    assert_ack_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(bit_cnt) == FULL);

    assert_ack_changes_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_lvl);

    assert_strobe_then_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> sda_pull);

endmodule

// File: rtl/synth_word_regs.sv
module synth_word_regs
    import synth_i2c_pkg::*;
#(
    parameter int SF_BITS = 15,
    parameter int SW_BITS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_vld,
    input  logic               txn_start,
    input  logic [7:0]         rx_byte,
    output logic [SF_BITS-1:0] scale_factor,
    output logic               cp_high,
    output logic               div_test,
    output logic               cp_off,
    output logic               drv_off,
    output logic [SW_BITS-1:0] sw_on
);
    localparam int HI_BITS = SF_BITS - 8;

    pair_phase_t        phase;
    logic [HI_BITS-1:0] hi_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase        <= PH_FIRST;
            hi_hold      <= '0;
            scale_factor <= '0;
            cp_high      <= 1'b0;
            div_test     <= 1'b0;
            cp_off       <= 1'b0;
            drv_off      <= 1'b0;
            sw_on        <= '0;
        end else if (txn_start) begin
            phase <= PH_FIRST;
        end else if (byte_vld) begin
            unique case (phase)
                PH_FIRST: begin
                    if (rx_byte[7]) begin
                        cp_high  <= rx_byte[6];
                        div_test <= rx_byte[5];
                        cp_off   <= rx_byte[4];
                        drv_off  <= rx_byte[0];
                        phase    <= PH_CTL2;
                    end else begin
                        hi_hold <= rx_byte[HI_BITS-1:0];
                        phase   <= PH_DIV2;
                    end
                end
                PH_DIV2: begin
                    scale_factor <= {hi_hold, rx_byte};
                    phase        <= PH_FIRST;
                end
                PH_CTL2: begin
                    sw_on <= {rx_byte[7:4], rx_byte[1]};
                    phase <= PH_FIRST;
                end
                default: phase <= PH_FIRST;
            endcase
        end
    end

    assert_sf_single_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scale_factor) |-> $past(byte_vld && phase == PH_DIV2));

    assert_ctl_from_opener_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cp_high, div_test, cp_off, drv_off})
            |-> $past(byte_vld && phase == PH_FIRST && rx_byte[7]));

    assert_sw_from_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sw_on) |-> $past(byte_vld && phase == PH_CTL2));

endmodule

// File: rtl/synth_i2c_prog.sv
module synth_i2c_prog #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] ADDR_HI     = 5'b11000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [1:0]  addr_sel,
    output logic        sda_pull,
    output logic [14:0] scale_factor,
    output logic        cp_high,
    output logic        div_test,
    output logic        cp_off,
    output logic        drv_off,
    output logic [4:0]  sw_on
);
    logic       sda_lvl, scl_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic       byte_vld, txn_start;
    logic [7:0] rx_byte;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl(sda_lvl), .scl_lvl(scl_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2c_slave_fsm #(.BYTE_BITS(8), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_lvl(scl_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
        .stop_evt(stop_evt), .addr_sel(addr_sel), .sda_pull(sda_pull),
        .byte_vld(byte_vld), .txn_start(txn_start), .rx_byte(rx_byte)
    );

    synth_word_regs #(.SF_BITS(15), .SW_BITS(5)) u_regs (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .txn_start(txn_start),
        .rx_byte(rx_byte), .scale_factor(scale_factor), .cp_high(cp_high),
        .div_test(div_test), .cp_off(cp_off), .drv_off(drv_off), .sw_on(sw_on)
    );

    assert_no_pull_in_reset_R8: assert property (@(posedge clk)
        !rst_n |-> !sda_pull);

endmodule

// File: tb/sim_synth_i2c_prog.sv
module sim_synth_i2c_prog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'd0;
    logic        sda_pull;
    logic [14:0] scale_factor;
    logic        cp_high, div_test, cp_off, drv_off;
    logic [4:0]  sw_on;
    logic        sda_line;

    int errors = 0;
    int checks = 0;

    logic [14:0] exp_sf  = '0;
    logic [3:0]  exp_ctl = '0;
    logic [4:0]  exp_sw  = '0;

    logic [7:0] msg [0:5];
    int         msg_len;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    synth_i2c_prog u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel(addr_sel), .sda_pull(sda_pull), .scale_factor(scale_factor),
        .cp_high(cp_high), .div_test(div_test), .cp_off(cp_off),
        .drv_off(drv_off), .sw_on(sw_on)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (10) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic acked, output logic freed);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; half();
            scl_m = 1'b1; half();
            scl_m = 1'b0; half();
        end
        sda_m = 1'b1; half();
        scl_m = 1'b1;
        repeat (5) @(negedge clk);
        acked = (sda_line == 1'b0);
        repeat (5) @(negedge clk);
        scl_m = 1'b0; half();
        freed = (sda_pull == 1'b0);
    endtask

    task automatic check_outputs(input string req);
        chk(req, 32'(scale_factor), 32'(exp_sf));
        chk(req, 32'({cp_high, div_test, cp_off, drv_off}), 32'(exp_ctl));
        chk(req, 32'(sw_on), 32'(exp_sw));
    endtask

    // expected effect of a matched transfer, from R4..R7
    task automatic model_msg();
        int ph = 0;
        logic [6:0] hi = '0;
        for (int i = 1; i < msg_len; i++) begin
            logic [7:0] b = msg[i];
            if (ph == 0) begin
                if (b[7]) begin exp_ctl = {b[6], b[5], b[4], b[0]}; ph = 2; end
                else begin hi = b[6:0]; ph = 1; end
            end else if (ph == 1) begin
                exp_sf = {hi, b}; ph = 0;
            end else begin
                exp_sw = {b[7:4], b[1]}; ph = 0;
            end
        end
    endtask

    task automatic run_msg(input logic exp_ack, input string req_addr, input string req_out);
        logic a, f;
        i2c_start();
        for (int i = 0; i < msg_len; i++) begin
            wr_byte(msg[i], a, f);
            if (i == 0) chk(req_addr, 32'(a), 32'(exp_ack));
            else if (exp_ack) chk("R2", 32'(a), 32'd1);
            else chk("R3", 32'(a), 32'd0);
            if (exp_ack) chk("R2", 32'(f), 32'd1);
        end
        i2c_stop();
        if (exp_ack) model_msg();
        check_outputs(req_out);
    endtask

    function automatic logic [7:0] addr_of(input logic [1:0] s);
        return {5'b11000, s, 1'b0};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a, f;
        repeat (5) @(negedge clk);
        // R8: reset state
        chk("R8", 32'(sda_pull), 32'd0);
        check_outputs("R8");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_outputs("R8");

        // R1 / R3: address sweep over all selects, plus read bit
        for (int s = 0; s < 4; s++) begin
            addr_sel = 2'(s);
            for (int c = 0; c < 4; c++) begin
                msg[0] = addr_of(2'(c));
                msg[1] = 8'h80 | 8'(s * 16 + c * 4 + 1);
                msg_len = 2;
                run_msg(c == s, (c == s) ? "R1" : "R3", (c == s) ? "R5" : "R3");
            end
            msg[0] = addr_of(2'(s)) | 8'h01;
            msg[1] = 8'hF1;
            msg[2] = 8'hFF;
            msg_len = 3;
            run_msg(1'b0, "R3", "R3");
        end

        addr_sel = 2'd2;
        // R4: scaling factor patterns and walking one
        for (int k = 0; k < 22; k++) begin
            logic [14:0] v;
            case (k)
                15: v = 15'h0000;
                16: v = 15'h7FFF;
                17: v = 15'h5555;
                18: v = 15'h2AAA;
                19: v = 15'h00FF;
                20: v = 15'h7F00;
                21: v = 15'h1234;
                default: v = 15'(1) << k;
            endcase
            msg[0] = addr_of(2'd2);
            msg[1] = {1'b0, v[14:8]};
            msg[2] = v[7:0];
            msg_len = 3;
            run_msg(1'b1, "R1", "R4");
        end

        // R5: control flags with unused bits toggled
        for (int v = 0; v < 16; v++) begin
            msg[0] = addr_of(2'd2);
            msg[1] = {1'b1, 4'(v) & 4'b1110, 3'(v), 4'(v) & 4'b0001};
            msg[1] = {1'b1, v[3], v[2], v[1], 3'(15 - v), v[0]};
            msg_len = 2;
            run_msg(1'b1, "R1", "R5");
        end

        // R6: switch byte sweep with unused bits set from pattern
        for (int v = 0; v < 32; v++) begin
            msg[0] = addr_of(2'd2);
            msg[1] = 8'h80;
            msg[2] = {v[4], v[3], v[2], v[1], v[2], ~v[0], v[0], v[3]};
            msg_len = 3;
            run_msg(1'b1, "R1", "R6");
        end

        // R7: control pair then divider pair, and the reverse
        msg[0] = addr_of(2'd2); msg[1] = 8'hD1; msg[2] = 8'hA2;
        msg[3] = 8'h2B; msg[4] = 8'hCD; msg_len = 5;
        run_msg(1'b1, "R1", "R7");
        msg[0] = addr_of(2'd2); msg[1] = 8'h61; msg[2] = 8'h07;
        msg[3] = 8'hA1; msg[4] = 8'h50; msg_len = 5;
        run_msg(1'b1, "R1", "R7");

        // R4: divider byte 1 alone leaves scale_factor unchanged
        msg[0] = addr_of(2'd2); msg[1] = 8'h3C; msg_len = 2;
        run_msg(1'b1, "R1", "R4");
        chk("R4", 32'(scale_factor), 32'h6107);

        // R7: incomplete pair does not carry over to next transfer
        msg[0] = addr_of(2'd2); msg[1] = 8'hC0; msg_len = 2;
        run_msg(1'b1, "R1", "R7");
        chk("R7", 32'(scale_factor), 32'h6107);

        // R3: foreign address, following data must have no effect
        msg[0] = addr_of(2'd1); msg[1] = 8'h55; msg[2] = 8'h55;
        msg[3] = 8'hFF; msg[4] = 8'hFF; msg_len = 5;
        run_msg(1'b0, "R3", "R3");

        // R9: repeated START aborts divider pair, new transfer decoded
        i2c_start();
        wr_byte(addr_of(2'd2), a, f); chk("R9", 32'(a), 32'd1);
        wr_byte(8'h12, a, f);         chk("R9", 32'(a), 32'd1);
        i2c_start();
        wr_byte(addr_of(2'd2), a, f); chk("R9", 32'(a), 32'd1);
        wr_byte(8'hC0, a, f);         chk("R9", 32'(a), 32'd1);
        wr_byte(8'hF2, a, f);         chk("R9", 32'(a), 32'd1);
        i2c_stop();
        exp_ctl = 4'b1000;
        exp_sw  = 5'b11111;
        check_outputs("R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule